// File: doc/BRIEF.md
# Word-Clock Ratio and Bit-Clock Mode Detector

This block runs entirely on the master clock of an audio converter front end. Two asynchronous inputs come into it: the word clock, and a shared control pin. The shared pin carries one of two things. It can carry a free-running external bit clock. If no bit clock is present, it carries a static level that asks for de-emphasis.

Every word-clock period, the block counts how many master-clock cycles the period spans. It compares that count against the ten legal master-to-word ratios and reports a small code for the matching ratio. A new ratio is only reported once two periods in a row agree. The block watches the shared pin for bursts of rising edges to decide whether an external bit clock is driving it. It switches to external mode quickly and returns to internal mode more slowly. While in internal mode, the block samples the pin's level on each word-clock falling edge to turn de-emphasis on or off. De-emphasis is only granted when the settled ratio implies a sample rate below 50 kHz, given the nominal master-clock frequency parameter.

Top module: `clkmode_detect`

## Requirements
- R1: After synchronous reset, the outputs are as follows:
  - `ratio_ok` is 0.
  - `ratio_code` is 15.
  - `ext_bclk` is 0.
  - `deemph_on` is 0.
- R2: A measurement is the number of master-clock cycles from one word-clock rising edge to the next. Legal measurements map to codes in ascending order of ratio: 64→0, 96→1, 128→2, 192→3, 256→4, 384→5, 512→6, 768→7, 1024→8, 1152→9.
- R3: A measurement that is not a legal ratio clears `ratio_ok` and sets `ratio_code` to 15.
- R4: A legal measurement is accepted only when it equals the immediately preceding measurement. A measurement that differs from the one before it clears `ratio_ok` until two equal legal measurements follow.
- R5: If no word-clock rising edge arrives for 2^CNT_W−1 master cycles (4095 by default), `ratio_ok` drops and `ratio_code` becomes 15.
- R6: External mode is entered when the shared pin shows 16 rising edges within one word-clock phase (high or low half). 15 rising edges in a phase do not enter it.
- R7: External mode is left after two consecutive word-clock periods (rising edge to rising edge) with no rising edge on the shared pin. A single quiet period does not leave it.
- R8: In internal mode, the pin is sampled at each word-clock falling edge. Five consecutive low samples turn de-emphasis on, and five consecutive high samples turn it off. Four consecutive samples of either level change nothing.
- R9: `deemph_on` is 1 only while the accepted ratio is valid and at least MCLK_HZ/50000+1 (492 by default, so ratios 512 and up). A request made at a faster rate takes effect once a slow ratio is accepted.
- R10: While in external mode, `deemph_on` is 0 and the de-emphasis request is cleared. Level samples taken during external mode do not count toward a later run of five.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wclk_in | input | 1 | Asynchronous word clock |
| shared_in | input | 1 | Shared bit-clock / de-emphasis pin, asynchronous |
| ratio_code | output | 4 | Accepted ratio code (0..9), 15 when not valid |
| ratio_ok | output | 1 | Ratio settled and legal |
| ext_bclk | output | 1 | External bit clock detected |
| deemph_on | output | 1 | De-emphasis enable |

## Verification
The assertions assume the following about the inputs:
- Both inputs arrive through identical two-flop synchronizers, so the pin and the word clock keep their relative timing.
- Each word-clock half lasts far longer than the synchronizer latency, so every edge is seen as a single-cycle strobe.

The bench drives both inputs from one task on the master clock. It keeps every half period at 32 cycles or more. Pin bursts use four-cycle pulses that start at the phase boundary and end well inside the phase. Pin levels are held static across each falling edge in internal mode.

// File: rtl/clkdet_pkg.sv
package clkdet_pkg;
  localparam int NUM_RATIOS = 10;
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_NONE = 4'hF;

  // legal master/word ratios, indexed by their output code
  function automatic int unsigned legal_ratio(input int unsigned idx);
    case (idx)
      0: legal_ratio = 64;
      1: legal_ratio = 96;
      2: legal_ratio = 128;
      3: legal_ratio = 192;
      4: legal_ratio = 256;
      5: legal_ratio = 384;
      6: legal_ratio = 512;
      7: legal_ratio = 768;
      8: legal_ratio = 1024;
      9: legal_ratio = 1152;
      default: legal_ratio = 0;
    endcase
  endfunction
endpackage

// File: rtl/clkdet_sync.sv
module clkdet_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/clkdet_ratio.sv
module clkdet_ratio
  import clkdet_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int SLOW_MIN = 492
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wclk_rise,
  output logic [CODE_W-1:0] ratio_code,
  output logic              ratio_ok,
  output logic              slow_ok
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0]      cnt;
  logic                  armed;
  logic [CNT_W:0]        period;
  logic [NUM_RATIOS-1:0] hit;
  logic [CODE_W-1:0]     meas_code;
  logic [CODE_W-1:0]     prev_code;
  logic                  sat;
  logic                  meas_stb;

  assign sat      = (cnt == CNT_MAX);
  assign period   = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign meas_stb = wclk_rise && armed;

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_match
    assign hit[g] = (period == (CNT_W+1)'(legal_ratio(g)));
  end

  always_comb begin
    meas_code = CODE_NONE;
    for (int i = 0; i < NUM_RATIOS; i++)
      if (hit[i]) meas_code = CODE_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      armed      <= 1'b0;
      prev_code  <= CODE_NONE;
      ratio_code <= CODE_NONE;
      ratio_ok   <= 1'b0;
      slow_ok    <= 1'b0;
    end else begin
      if (wclk_rise) begin
        cnt   <= '0;
        armed <= 1'b1;
      end else if (!sat) begin
        cnt <= cnt + 1'b1;
      end

      if (meas_stb) begin
        prev_code <= meas_code;
        if (meas_code != CODE_NONE && meas_code == prev_code) begin
          ratio_ok   <= 1'b1;
          ratio_code <= meas_code;
          slow_ok    <= (period >= (CNT_W+1)'(SLOW_MIN));
        end else begin
          ratio_ok   <= 1'b0;
          ratio_code <= CODE_NONE;
          slow_ok    <= 1'b0;
        end
      end else if (sat && !wclk_rise) begin
        prev_code  <= CODE_NONE;
        ratio_ok   <= 1'b0;
        ratio_code <= CODE_NONE;
        slow_ok    <= 1'b0;
      end
    end
  end

  p_code_range_r3: assert property (@(posedge clk) disable iff (rst)
    ratio_ok |-> (ratio_code < CODE_W'(NUM_RATIOS)));
  p_invalid_code_r3: assert property (@(posedge clk) disable iff (rst)
    !ratio_ok |-> (ratio_code == CODE_NONE));
  p_accept_on_meas_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ratio_ok) |-> $past(meas_stb));
  p_stall_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (sat && !wclk_rise) |=> !ratio_ok);
endmodule

// File: rtl/clkdet_bclk.sv
module clkdet_bclk #(
  parameter int ENTER_EDGES  = 16,
  parameter int QUIET_FRAMES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_rise,
  input  logic wclk_rise,
  input  logic wclk_edge,
  output logic ext_mode
);
  localparam int EW = $clog2(ENTER_EDGES + 1);
  localparam int QW = $clog2(QUIET_FRAMES + 1);

  logic [EW-1:0] ecnt;
  logic [QW-1:0] qcnt;
  logic          seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      ecnt     <= '0;
      qcnt     <= '0;
      seen     <= 1'b0;
      ext_mode <= 1'b0;
    end else begin
      // rising edges counted inside the current word-clock phase
      if (wclk_edge)
        ecnt <= pin_rise ? EW'(1) : '0;
      else if (pin_rise && ecnt != EW'(ENTER_EDGES))
        ecnt <= ecnt + 1'b1;

      if (!wclk_edge && pin_rise && ecnt == EW'(ENTER_EDGES - 1))
        ext_mode <= 1'b1;

      // quiet frame tracking, frame = rising edge to rising edge
      if (wclk_rise) begin
        seen <= pin_rise;
        if (seen || pin_rise) begin
          qcnt <= '0;
        end else if (qcnt == QW'(QUIET_FRAMES - 1)) begin
          qcnt     <= '0;
          ext_mode <= 1'b0;
        end else begin
          qcnt <= qcnt + 1'b1;
        end
      end else if (pin_rise) begin
        seen <= 1'b1;
      end
    end
  end

  p_enter_on_edge_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_mode) |-> $past(pin_rise));
  p_leave_on_frame_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(ext_mode) |-> $past(wclk_rise));
endmodule

// File: rtl/clkdet_deemph.sv
module clkdet_deemph #(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic wclk_fall,
  input  logic pin_lvl,
  input  logic ext_mode,
  input  logic slow_ok,
  output logic deemph_on
);
  localparam int RW = $clog2(RUN_LEN + 1);

  logic [RW-1:0] run;
  logic          last_lvl;
  logic          req;

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= '0;
      last_lvl  <= 1'b0;
      req       <= 1'b0;
      deemph_on <= 1'b0;
    end else begin
      if (ext_mode) begin
        run <= '0;
        req <= 1'b0;
      end else if (wclk_fall) begin
        if (run != '0 && pin_lvl == last_lvl) begin
          if (run != RW'(RUN_LEN)) run <= run + 1'b1;
          if (run == RW'(RUN_LEN - 1)) req <= !pin_lvl;
        end else begin
          run      <= RW'(1);
          last_lvl <= pin_lvl;
        end
      end
      deemph_on <= req && !ext_mode && slow_ok;
    end
  end

  p_req_on_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(req) |-> $past(wclk_fall));
  p_slow_gate_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(deemph_on) |-> $past(slow_ok));
  p_ext_blocks_r10: assert property (@(posedge clk) disable iff (rst)
    (ext_mode && $past(ext_mode)) |-> !deemph_on);
endmodule

// File: rtl/clkmode_detect.sv
module clkmode_detect
  import clkdet_pkg::*;
#(
  parameter int MCLK_HZ      = 24_576_000,
  parameter int DEEMPH_FS_HZ = 50_000,
  parameter int CNT_W        = 12,
  parameter int SYNC_STAGES  = 2,
  parameter int ENTER_EDGES  = 16,
  parameter int QUIET_FRAMES = 2,
  parameter int DEEMPH_RUN   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wclk_in,
  input  logic              shared_in,
  output logic [CODE_W-1:0] ratio_code,
  output logic              ratio_ok,
  output logic              ext_bclk,
  output logic              deemph_on
);
  localparam int SLOW_MIN = MCLK_HZ / DEEMPH_FS_HZ + 1;

  logic [1:0] sync_q;
  logic       wclk_s, pin_s;
  logic       wclk_d, pin_d;
  logic       wclk_rise, wclk_fall, wclk_edge, pin_rise;
  logic       slow_ok;

  clkdet_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({wclk_in, shared_in}), .q(sync_q)
  );

  assign wclk_s = sync_q[1];
  assign pin_s  = sync_q[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wclk_d <= 1'b0;
      pin_d  <= 1'b0;
    end else begin
      wclk_d <= wclk_s;
      pin_d  <= pin_s;
    end
  end

  assign wclk_rise = wclk_s && !wclk_d;
  assign wclk_fall = !wclk_s && wclk_d;
  assign wclk_edge = wclk_rise || wclk_fall;
  assign pin_rise  = pin_s && !pin_d;

  clkdet_ratio #(.CNT_W(CNT_W), .SLOW_MIN(SLOW_MIN)) u_ratio (
    .clk(clk), .rst(rst), .wclk_rise(wclk_rise),
    .ratio_code(ratio_code), .ratio_ok(ratio_ok), .slow_ok(slow_ok)
  );

  clkdet_bclk #(.ENTER_EDGES(ENTER_EDGES), .QUIET_FRAMES(QUIET_FRAMES)) u_bclk (
    .clk(clk), .rst(rst), .pin_rise(pin_rise), .wclk_rise(wclk_rise),
    .wclk_edge(wclk_edge), .ext_mode(ext_bclk)
  );

  clkdet_deemph #(.RUN_LEN(DEEMPH_RUN)) u_deemph (
    .clk(clk), .rst(rst), .wclk_fall(wclk_fall), .pin_lvl(pin_s),
    .ext_mode(ext_bclk), .slow_ok(slow_ok), .deemph_on(deemph_on)
  );
endmodule

// File: tb/sim_clkmode_detect.sv
`timescale 1ns/1ps
module sim_clkmode_detect;
  logic       clk = 1'b0;
  logic       rst;
  logic       wclk_in;
  logic       shared_in;
  logic [3:0] ratio_code;
  logic       ratio_ok, ext_bclk, deemph_on;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  clkmode_detect u0 (
    .clk(clk), .rst(rst), .wclk_in(wclk_in), .shared_in(shared_in),
    .ratio_code(ratio_code), .ratio_ok(ratio_ok),
    .ext_bclk(ext_bclk), .deemph_on(deemph_on)
  );

  task automatic chk(input int act, input int exp, input string req);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // k word-clock periods of n cycles; 'rises' pin pulses at the start of each half,
  // otherwise the pin rests at 'lvl'
  task automatic gen(input int n, input int k, input int rises, input logic lvl);
    for (int p = 0; p < k; p++) begin
      for (int c = 0; c < n; c++) begin
        @(posedge clk); #1;
        begin
          int half = n / 2;
          int pos  = (c < half) ? c : c - half;
          wclk_in   = (c < half);
          shared_in = (pos < 4 * rises) ? ((pos % 4) < 2) : lvl;
        end
      end
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; wclk_in = 1'b0; shared_in = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    chk(ratio_ok, 0, "R1 ratio_ok");
    chk(ratio_code, 15, "R1 ratio_code");
    chk(ext_bclk, 0, "R1 ext_bclk");
    chk(deemph_on, 0, "R1 deemph_on");
    rst = 1'b0;
  endtask

  task automatic t_ratio(input int n, input int k, input int code);
    gen(n, k, 0, 1'b1);
    chk(ratio_ok, 1, $sformatf("R2 ok for %0d", n));
    chk(ratio_code, code, $sformatf("R2 code for %0d", n));
  endtask

  task automatic t_illegal();
    gen(300, 3, 0, 1'b1);
    chk(ratio_ok, 0, "R3 ok for 300");
    chk(ratio_code, 15, "R3 code for 300");
  endtask

  task automatic t_settle();
    gen(256, 3, 0, 1'b1);
    chk(ratio_code, 4, "R4 before change");
    gen(512, 2, 0, 1'b1);
    chk(ratio_ok, 0, "R4 one new measurement");
    gen(512, 1, 0, 1'b1);
    chk(ratio_ok, 1, "R4 two equal measurements");
    chk(ratio_code, 6, "R4 new code");
  endtask

  task automatic t_stall();
    repeat (3000) @(posedge clk);
    #1;
    chk(ratio_ok, 1, "R5 short stall");
    repeat (1500) @(posedge clk);
    #1;
    chk(ratio_ok, 0, "R5 long stall ok");
    chk(ratio_code, 15, "R5 long stall code");
  endtask

  task automatic t_enter();
    gen(256, 3, 15, 1'b0);
    chk(ext_bclk, 0, "R6 fifteen edges");
    gen(256, 1, 16, 1'b0);
    chk(ext_bclk, 1, "R6 sixteen edges");
  endtask

  task automatic t_leave();
    gen(256, 2, 0, 1'b0);
    chk(ext_bclk, 1, "R7 one quiet frame");
    gen(256, 1, 0, 1'b0);
    chk(ext_bclk, 0, "R7 two quiet frames");
  endtask

  task automatic t_deemph_run();
    gen(512, 4, 0, 1'b1);
    chk(deemph_on, 0, "R8 high level");
    gen(512, 4, 0, 1'b0);
    chk(deemph_on, 0, "R8 four lows");
    gen(512, 1, 0, 1'b0);
    chk(deemph_on, 1, "R8 five lows");
    gen(512, 4, 0, 1'b1);
    chk(deemph_on, 1, "R8 four highs");
    gen(512, 1, 0, 1'b1);
    chk(deemph_on, 0, "R8 five highs");
  endtask

  task automatic t_rate_gate();
    gen(256, 10, 0, 1'b0);
    chk(ratio_code, 4, "R9 fast ratio");
    chk(deemph_on, 0, "R9 fast rate blocks");
    gen(512, 3, 0, 1'b0);
    chk(deemph_on, 1, "R9 slow rate grants");
  endtask

  task automatic t_ext_block();
    gen(512, 1, 16, 1'b0);
    chk(ext_bclk, 1, "R10 ext entered");
    chk(deemph_on, 0, "R10 forced off");
    gen(512, 2, 0, 1'b0);
    chk(deemph_on, 0, "R10 still external");
    gen(512, 1, 0, 1'b0);
    chk(ext_bclk, 0, "R10 back to internal");
    chk(deemph_on, 0, "R10 fresh run needed");
    gen(512, 4, 0, 1'b0);
    chk(deemph_on, 1, "R10 five new lows");
  endtask

  initial begin
    t_reset();
    t_ratio(256, 4, 4);
    t_ratio(1152, 3, 9);
    t_ratio(64, 3, 0);
    t_ratio(96, 3, 1);
    t_illegal();
    t_settle();
    t_stall();
    t_enter();
    t_leave();
    t_deemph_run();
    t_rate_gate();
    t_ext_block();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule